// File: doc/BRIEF.md
# Ethernet receive framing front end

This block sits behind a recovered receive bit stream that arrives one bit per clock while a data-valid strobe is high. It looks for the alternating preamble and takes the start-of-frame delimiter as the byte boundary. It then builds bytes least-significant bit first and decides from the six destination address bytes whether the frame is wanted. Frames that are wanted leave as a byte stream with a start marker. The four check bytes stay on the end of the stream.

The destination bytes are held until the filter decides. They are then released back to back, and every later byte follows on the cycle it completes. A CRC-32 runs over every bit after the delimiter. When the strobe falls, an end-of-frame pulse reports whether the frame was clean. A fall that is not on a byte boundary always reports a bad frame. Frames that fail the filter, or that end before the address is complete, produce no output at all.

Top module: `rx_frame_front`

## Requirements
- R1: While rst_ni is low, byte_vld_o, sof_o and eof_o are low.
- R2: The delimiter is the wire-order bit sequence 1,0,1,0,1,0,1,1. It is recognised once at least 8 bits of the current valid burst have arrived. The bit after it is bit 0 of the first destination byte, and each byte is assembled with its first received bit in bit 0.
- R3: Bits are numbered from 1 at the rise of bit_vld_i. A bit numbered 10 or later that equals the bit before it, and that does not complete the delimiter, abandons the attempt. Nothing from that valid burst is then output, even if a delimiter and a frame follow.
- R4: Repeated bits among the first 9 bits of a burst do not abandon the attempt.
- R5: With promisc_i low and bit 0 of the first destination byte at 0, a frame passes only if all six destination bytes match node_addr_i. The first byte is compared with node_addr_i[47:40] and the last with node_addr_i[7:0]. A failing frame produces no byte and no eof_o.
- R6: When bit 0 of the first destination byte is 1 and promisc_i is low, the frame passes exactly when mcast_all_i is high.
- R7: With promisc_i high, every frame passes whatever its destination address.
- R8: A passing frame outputs every byte after the delimiter in order, the check bytes included. Each byte comes with a one-cycle byte_vld_o pulse, and sof_o is high only with the first byte.
- R9: When bit_vld_i falls on a byte boundary after a passing frame, eof_o pulses once for one cycle, after the last byte and never together with byte_vld_o. good_o is 1 at that pulse exactly when the CRC-32 over all bits after the delimiter gives the residue 0xC704DD7B. The CRC uses polynomial 0x04C11DB7, starts from all ones and takes bits in wire order.
- R10: When bit_vld_i falls with a partial byte pending, the complete bytes are still output, eof_o still pulses, and good_o is 0.
- R11: When bit_vld_i falls before the sixth destination byte completes, nothing is output and no eof_o occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one wire bit per cycle while valid |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Received wire bit |
| bit_vld_i | input | 1 | High for each cycle that carries a bit; its fall ends the frame |
| node_addr_i | input | 48 | Programmed station address, first wire byte in bits 47:40 |
| promisc_i | input | 1 | Accept every frame |
| mcast_all_i | input | 1 | Accept every group-addressed frame |
| byte_o | output | 8 | Output frame byte |
| byte_vld_o | output | 1 | byte_o holds a frame byte this cycle |
| sof_o | output | 1 | First byte of a frame |
| eof_o | output | 1 | One-cycle end-of-frame pulse |
| good_o | output | 1 | Frame status, meaningful with eof_o |

## Verification
The main path is driven with a clean preamble and delimiter followed by frames whose destination is an exact station match, a station address that differs only in its last byte, and a group address. These patterns separate a full 48-bit compare from a partial one and the group rule from the station rule. The same frames are sent again with promiscuous and accept-group settings, with one payload bit flipped after the check bytes were computed, and with three extra dribble bits. The flipped bit separates residue checking from plain length checking, and the dribble bits separate boundary-aligned endings from unaligned ones. The preamble is also given a doubled bit late in the stream and, separately, early junk bits, which shows the abort window starts where it should. A stream cut inside the address shows that nothing leaks out before the filter has decided.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [7:0]  SFD_SEQ     = 8'b1010_1011;  // wire order, oldest bit on the left
  localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_DROP = 2'd2
  } rx_st_e;
endpackage

// File: rtl/rx_sync_hunt.sv
module rx_sync_hunt #(
  parameter int LOCK_BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic sfd_o,
  output logic abort_o
);
  import rxf_pkg::*;

  localparam int CW = $clog2(LOCK_BITS + 3);
  localparam logic [CW-1:0] CMAX = '1;

  logic [6:0]    sh_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    sh_nxt;

  assign sh_nxt = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else begin
      sh_q <= sh_nxt[6:0];
      if (cnt_q != CMAX) cnt_q <= cnt_q + CW'(1);
    end
  end

  // cnt_q counts bits before the current one
  assign sfd_o   = en_i && (cnt_q >= CW'(7)) && (sh_nxt == SFD_SEQ);
  assign abort_o = en_i && !sfd_o && (cnt_q >= CW'(LOCK_BITS + 1)) && (bit_i == sh_q[0]);
endmodule

// File: rtl/rx_crc32.sv
module rx_crc32 #(
  parameter logic [31:0] POLY    = rxf_pkg::CRC_POLY,
  parameter logic [31:0] RESIDUE = rxf_pkg::CRC_RESIDUE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic en_i,
  input  logic bit_i,
  output logic ok_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= {crc_q[30:0], 1'b0} ^ ((crc_q[31] ^ bit_i) ? POLY : 32'd0);
  end

  assign ok_o = (crc_q == RESIDUE);
endmodule

// File: rtl/rx_addr_filt.sv
module rx_addr_filt #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    stb_i,
  input  logic [7:0]              byte_i,
  input  logic [8*ADDR_BYTES-1:0] node_addr_i,
  input  logic                    promisc_i,
  input  logic                    mcast_all_i,
  input  logic [$clog2(ADDR_BYTES)-1:0] rd_idx_i,
  output logic                    done_o,
  output logic                    pass_o,
  output logic [7:0]              rd_byte_o
);
  localparam int IW = $clog2(ADDR_BYTES + 1);
  localparam int RW = $clog2(ADDR_BYTES);

  logic [7:0]    buf_q  [ADDR_BYTES];
  logic [7:0]    node_b [ADDR_BYTES];
  logic [IW-1:0] idx_q;
  logic          match_q, mcast_q;
  logic          collecting, byte_hit, first_mc;

  genvar g;
  generate
    for (g = 0; g < ADDR_BYTES; g++) begin : g_node
      assign node_b[g] = node_addr_i[8*(ADDR_BYTES-1-g) +: 8];
    end
  endgenerate

  assign collecting = (idx_q < IW'(ADDR_BYTES));
  assign byte_hit   = (byte_i == node_b[idx_q[RW-1:0]]);
  assign first_mc   = (idx_q == '0) ? byte_i[0] : mcast_q;
  assign done_o     = stb_i && (idx_q == IW'(ADDR_BYTES - 1));
  assign pass_o     = promisc_i || (first_mc ? mcast_all_i : (match_q && byte_hit));
  assign rd_byte_o  = buf_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ADDR_BYTES; i++) buf_q[i] <= '0;
      idx_q   <= IW'(ADDR_BYTES);
      match_q <= 1'b0;
      mcast_q <= 1'b0;
    end else if (start_i) begin
      idx_q   <= '0;
      match_q <= 1'b1;
      mcast_q <= 1'b0;
    end else if (stb_i && collecting) begin
      buf_q[idx_q[RW-1:0]] <= byte_i;
      idx_q   <= idx_q + IW'(1);
      match_q <= match_q && byte_hit;
      if (idx_q == '0) mcast_q <= byte_i[0];
    end
  end
endmodule

// File: rtl/rx_frame_front.sv
module rx_frame_front #(
  parameter int LOCK_BITS  = 8,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bit_i,
  input  logic                    bit_vld_i,
  input  logic [8*ADDR_BYTES-1:0] node_addr_i,
  input  logic                    promisc_i,
  input  logic                    mcast_all_i,
  output logic [7:0]              byte_o,
  output logic                    byte_vld_o,
  output logic                    sof_o,
  output logic                    eof_o,
  output logic                    good_o
);
  import rxf_pkg::*;

  localparam int RW = $clog2(ADDR_BYTES);

  rx_st_e        st_q;
  logic [2:0]    bcnt_q;
  logic [6:0]    sr_q;
  logic          fwd_q, burst_q, end_pend_q, end_good_q;
  logic [RW-1:0] bidx_q, rd_idx;
  logic          hunt_en, data_bit, byte_stb;
  logic [7:0]    byte_nxt, rd_byte;
  logic          sfd_hit, pre_abort, crc_ok, flt_done, flt_pass;

  assign hunt_en  = (st_q == ST_HUNT) && bit_vld_i;
  assign data_bit = (st_q == ST_DATA) && bit_vld_i;
  assign byte_stb = data_bit && (bcnt_q == 3'd7);
  assign byte_nxt = {bit_i, sr_q};
  assign rd_idx   = burst_q ? bidx_q : '0;

  rx_sync_hunt #(.LOCK_BITS(LOCK_BITS)) u_hunt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (hunt_en),
    .bit_i   (bit_i),
    .sfd_o   (sfd_hit),
    .abort_o (pre_abort)
  );

  rx_crc32 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (sfd_hit),
    .en_i   (data_bit),
    .bit_i  (bit_i),
    .ok_o   (crc_ok)
  );

  rx_addr_filt #(.ADDR_BYTES(ADDR_BYTES)) u_filt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (sfd_hit),
    .stb_i       (byte_stb),
    .byte_i      (byte_nxt),
    .node_addr_i (node_addr_i),
    .promisc_i   (promisc_i),
    .mcast_all_i (mcast_all_i),
    .rd_idx_i    (rd_idx),
    .done_o      (flt_done),
    .pass_o      (flt_pass),
    .rd_byte_o   (rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_HUNT;
      bcnt_q     <= '0;
      sr_q       <= '0;
      fwd_q      <= 1'b0;
      burst_q    <= 1'b0;
      bidx_q     <= '0;
      end_pend_q <= 1'b0;
      end_good_q <= 1'b0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      sof_o      <= 1'b0;
      eof_o      <= 1'b0;
      good_o     <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      sof_o      <= 1'b0;
      eof_o      <= 1'b0;

      unique case (st_q)
        ST_HUNT: begin
          if (sfd_hit) begin
            st_q   <= ST_DATA;
            bcnt_q <= '0;
            fwd_q  <= 1'b0;
          end else if (pre_abort) begin
            st_q <= ST_DROP;
          end
        end
        ST_DATA: begin
          if (bit_vld_i) begin
            bcnt_q <= bcnt_q + 3'd1;
            sr_q   <= {bit_i, sr_q[6:1]};
            if (byte_stb) begin
              if (!fwd_q) begin
                if (flt_done) begin
                  if (flt_pass) begin
                    // release held address bytes back to back
                    fwd_q      <= 1'b1;
                    byte_o     <= rd_byte;
                    byte_vld_o <= 1'b1;
                    sof_o      <= 1'b1;
                    burst_q    <= 1'b1;
                    bidx_q     <= RW'(1);
                  end else begin
                    st_q <= ST_DROP;
                  end
                end
              end else begin
                byte_o     <= byte_nxt;
                byte_vld_o <= 1'b1;
              end
            end
          end else begin
            st_q <= ST_HUNT;
            if (fwd_q) begin
              end_pend_q <= 1'b1;
              end_good_q <= (bcnt_q == 3'd0) && crc_ok;
            end
          end
        end
        default: begin
          if (!bit_vld_i) st_q <= ST_HUNT;
        end
      endcase

      if (burst_q) begin
        byte_o     <= rd_byte;
        byte_vld_o <= 1'b1;
        bidx_q     <= bidx_q + RW'(1);
        if (bidx_q == RW'(ADDR_BYTES - 1)) burst_q <= 1'b0;
      end

      if (end_pend_q && !burst_q) begin
        end_pend_q <= 1'b0;
        eof_o      <= 1'b1;
        good_o     <= end_good_q;
      end
    end
  end
endmodule

// File: rtl/rx_frame_front_chk.sv
module rx_frame_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_vld_o,
  input logic sof_o,
  input logic eof_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!byte_vld_o && !sof_o && !eof_o)
        else $error("R1 outputs active in reset");
    end
  end

  a_r8_sof_has_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> byte_vld_o) else $error("R8 sof without byte");

  a_r8_sof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o) else $error("R8 sof repeated");

  a_r9_eof_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> !byte_vld_o) else $error("R9 eof with byte");

  a_r9_eof_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o) else $error("R9 eof longer than one cycle");
endmodule

bind rx_frame_front rx_frame_front_chk u_chk (.*);

// File: tb/sim_rx_frame_front.sv
module sim_rx_frame_front;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_in = 1'b0;
  logic        vld = 1'b0;
  logic [47:0] node = 48'h02_11_22_33_44_55;
  logic        promisc = 1'b0;
  logic        mc_all = 1'b0;
  logic [7:0]  byte_o;
  logic        byte_vld_o, sof_o, eof_o, good_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_vld_i(vld),
    .node_addr_i(node), .promisc_i(promisc), .mcast_all_i(mc_all),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .sof_o(sof_o),
    .eof_o(eof_o), .good_o(good_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] fb [0:255];
  int flen = 0;
  logic wb [0:4095];
  int wn = 0;
  logic [7:0] cap [0:255];
  int cn = 0, sof_n = 0, sof_at = -1, eof_n = 0;
  logic eof_good = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld_o) begin
        if (sof_o) begin sof_n++; sof_at = cn; end
        if (cn < 256) cap[cn] = byte_o;
        cn++;
      end
      if (eof_o) begin eof_n++; eof_good = good_o; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    wb[wn] = b; wn++;
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) put_bit(b[i]);
  endtask

  task automatic put_pre();
    for (int i = 0; i < 7; i++) put_byte(8'h55);
    put_byte(8'hD5);
  endtask

  task automatic add_fcs();
    logic [31:0] c = 32'hFFFF_FFFF;
    logic f;
    for (int i = 0; i < flen; i++)
      for (int k = 0; k < 8; k++) begin
        f = c[0] ^ fb[i][k];
        c = c >> 1;
        if (f) c = c ^ 32'hEDB8_8320;
      end
    c = ~c;
    for (int k = 0; k < 4; k++) begin fb[flen] = c[8*k +: 8]; flen++; end
  endtask

  task automatic make_frame(input logic [47:0] da);
    flen = 0;
    for (int k = 0; k < 6; k++) begin fb[flen] = da[47-8*k -: 8]; flen++; end
    for (int k = 0; k < 6; k++) begin fb[flen] = 8'hA0 + 8'(k); flen++; end
    fb[flen] = 8'h08; flen++;
    fb[flen] = 8'h00; flen++;
    for (int k = 0; k < 46; k++) begin fb[flen] = 8'(k * 7 + 3); flen++; end
    add_fcs();
  endtask

  task automatic put_frame();
    for (int i = 0; i < flen; i++) put_byte(fb[i]);
  endtask

  task automatic run();
    cn = 0; sof_n = 0; sof_at = -1; eof_n = 0; eof_good = 1'b0;
    for (int i = 0; i < wn; i++) begin
      @(negedge clk); bit_in = wb[i]; vld = 1'b1;
    end
    @(negedge clk); vld = 1'b0; bit_in = 1'b0;
    repeat (20) @(negedge clk);
    wn = 0;
  endtask

  task automatic expect_frame(input string tag, input bit good);
    int bad = 0;
    chk(cn == flen, {tag, " byte count"}, cn, flen);
    for (int i = 0; i < flen && i < cn; i++) if (cap[i] !== fb[i]) bad++;
    chk(bad == 0, {tag, " byte values"}, bad, 0);
    chk(sof_n == 1 && sof_at == 0, {tag, " sof position"}, sof_at, 0);
    chk(eof_n == 1, {tag, " eof count"}, eof_n, 1);
    chk(eof_good == good, {tag, " good"}, int'(eof_good), int'(good));
  endtask

  task automatic expect_none(input string tag);
    chk(cn == 0, {tag, " no bytes"}, cn, 0);
    chk(eof_n == 0, {tag, " no eof"}, eof_n, 0);
  endtask

  task automatic t_reset();
    chk(byte_vld_o == 1'b0 && sof_o == 1'b0, "R1 byte/sof in reset", int'(byte_vld_o), 0);
    chk(eof_o == 1'b0, "R1 eof in reset", int'(eof_o), 0);
  endtask

  task automatic t_unicast_hit();
    promisc = 0; mc_all = 0;
    make_frame(node);
    put_pre(); put_frame(); run();
    expect_frame("R2 R5 R8 R9 unicast hit", 1'b1);
  endtask

  task automatic t_unicast_miss();
    promisc = 0; mc_all = 1;
    make_frame(48'h02_11_22_33_44_56);
    put_pre(); put_frame(); run();
    expect_none("R5 unicast last-byte miss");
  endtask

  task automatic t_multicast();
    promisc = 0; mc_all = 0;
    make_frame(48'h01_00_5E_00_00_01);
    put_pre(); put_frame(); run();
    expect_none("R6 group blocked");
    mc_all = 1;
    put_pre(); put_frame(); run();
    expect_frame("R6 group accepted", 1'b1);
    mc_all = 0;
  endtask

  task automatic t_promisc();
    promisc = 1;
    make_frame(48'h02_11_22_33_44_56);
    put_pre(); put_frame(); run();
    expect_frame("R7 promiscuous", 1'b1);
    promisc = 0;
  endtask

  task automatic t_bad_fcs();
    make_frame(node);
    fb[20] = fb[20] ^ 8'h01;
    put_pre(); put_frame(); run();
    expect_frame("R9 corrupted frame", 1'b0);
  endtask

  task automatic t_dribble();
    make_frame(node);
    put_pre(); put_frame();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    run();
    expect_frame("R10 dribble bits", 1'b0);
  endtask

  task automatic t_pair_abort();
    make_frame(node);
    for (int i = 0; i < 24; i++) put_bit((i % 2) == 0);
    put_bit(1'b0);  // bit 25 repeats bit 24
    put_pre(); put_frame(); run();
    expect_none("R3 late doubled bit");
  endtask

  task automatic t_lock_junk();
    make_frame(node);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    put_pre(); put_frame(); run();
    expect_frame("R4 early junk", 1'b1);
  endtask

  task automatic t_short();
    put_pre();
    put_byte(node[47:40]); put_byte(node[39:32]); put_byte(node[31:24]);
    run();
    expect_none("R11 cut in address");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_unicast_hit();
    t_unicast_miss();
    t_multicast();
    t_promisc();
    t_bad_fcs();
    t_dribble();
    t_pair_abort();
    t_lock_junk();
    t_short();
    t_unicast_hit();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule